// File: doc/BRIEF.md
# Byte-Write Configuration Serializer

This block is the receiving end of a byte-wide configuration path. A host that has no access to the configuration clock writes bytes over an asynchronous parallel bus. A write is qualified by two chip selects of opposite polarity and an active-low write strobe. The block brings the strobe into the configuration clock domain and latches the byte. It then sends the byte out as a serial stream, least significant bit first, with one bit on each falling edge of the configuration clock.

A ready output goes low as soon as a byte is accepted. It returns high once the byte has moved into the shift register and the holding register can take the next one, so the host can pace its writes on that pin alone. A host that prefers to poll can assert the read strobe with the port selected. The same ready flag then appears on data bit 7 together with an output enable. Bits 6 to 0 of the data bus have no driver in this block.

If a write completes while the block is still busy, the byte is dropped and a sticky error flag is set. The error flag clears only on reset.

Top module: `cfg_byte_serializer`

## Requirements
- R1: While reset is asserted and after reset, `ready` is 1, `serialOut` is 0, `overrunErr` is 0 and `d7OutEn` is 0.
- R2: A write is taken only while `selLowN` is 0, `selHigh` is 1 and `wrN` is 0 at the same time. A strobe with either select inactive leaves `ready`, `serialOut` and `overrunErr` unchanged.
- R3: The byte that is sent is the value of `dataIn` during the last clock period in which the qualified write was active. `dataIn` may change in the same instant that `wrN` rises.
- R4: After a write ends, `ready` goes low within 4 clock periods. It then stays low for at least 1 and at most 8 clock periods.
- R5: When the serializer is idle, the first falling edge after `ready` falls drives bit 0 of the byte onto `serialOut`. Each following falling edge drives the next higher bit, up to bit 7.
- R6: A byte that is accepted while the previous byte is still shifting starts on the falling edge that follows bit 7 of the previous byte, with no idle edge between them.
- R7: A write that completes while `ready` is 0 is discarded, and its data never appears on `serialOut`. It sets `overrunErr`, which stays 1 until reset.
- R8: `d7OutEn` is 1 exactly while `selLowN` is 0, `selHigh` is 1 and `rdN` is 0. `d7Out` equals the `ready` level (1 ready, 0 busy). No output drives data bits 6 to 0.
- R9: Once the last bit of a byte has been sent and no byte is waiting, `serialOut` keeps that bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; bits leave on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selLowN | input | 1 | Chip select, active low |
| selHigh | input | 1 | Chip select, active high |
| wrN | input | 1 | Write strobe, active low, asynchronous to clk |
| rdN | input | 1 | Status read strobe, active low |
| dataIn | input | 8 | Host write data |
| ready | output | 1 | 1 when a new byte can be written, 0 while busy |
| serialOut | output | 1 | Serial configuration data, LSB first |
| d7Out | output | 1 | Status value for data bit 7 during a read |
| d7OutEn | output | 1 | Output enable for data bit 7 |
| overrunErr | output | 1 | Sticky flag for a write dropped while busy |

## Verification
Two cases are hard to reach from the ports: a byte that must join the end of a running byte with no gap, and a write that completes inside the short busy window. The busy window lasts only a few cycles after synchronization. To reach both, the bench starts writes at a fixed offset from the rising edge of `ready`. It issues two single-cycle write pulses one cycle apart, so the first write is accepted while the first byte is still shifting and the second write is detected before that first byte has been loaded. A serial capture over sixteen falling edges then shows both the seamless join and the absence of the dropped byte.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic captureEn;   // raw qualified write is active: sample the bus
    logic holdLoad;    // write end accepted: fill the holding register
  } ctrlStrobe_t;

endpackage

// File: rtl/cfgser_ctrl.sv
module cfgser_ctrl
  import cfgser_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selLowN,
  input  logic        selHigh,
  input  logic        wrN,
  input  logic        rdN,
  input  logic        loadAck,
  output ctrlStrobe_t strobe,
  output logic        holdFull,
  output logic        ready,
  output logic        overrunErr,
  output logic        d7OutEn
);

  localparam int MAX_BUSY = DATA_W;
  localparam int BUSY_W   = $clog2(MAX_BUSY + 2);

  logic                   wrRaw;
  logic [SYNC_STAGES-1:0] wrSync;
  logic                   wrPrev;
  logic                   wrDone;

  assign wrRaw = !selLowN && selHigh && !wrN;

  // Synchronizer chain for the qualified write
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) wrSync[0] <= 1'b0;
          else       wrSync[0] <= wrRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) wrSync[gi] <= 1'b0;
          else       wrSync[gi] <= wrSync[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrPrev <= 1'b0;
    else       wrPrev <= wrSync[SYNC_STAGES-1];
  end

  // Trailing edge of the synchronized write
  assign wrDone = wrPrev && !wrSync[SYNC_STAGES-1];

  assign strobe.captureEn = wrRaw;
  assign strobe.holdLoad  = wrDone && ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready      <= 1'b1;
      holdFull   <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      if (wrDone && ready) begin
        ready    <= 1'b0;
        holdFull <= 1'b1;
      end else if (wrDone) begin
        overrunErr <= 1'b1;
      end
      if (loadAck) begin
        holdFull <= 1'b0;
        ready    <= 1'b1;
      end
    end
  end

  assign d7OutEn = !selLowN && selHigh && !rdN;

  // Busy-length monitor used by the bound check
  logic [BUSY_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 busyCnt <= '0;
    else if (ready)            busyCnt <= '0;
    else if (busyCnt <= BUSY_W'(MAX_BUSY)) busyCnt <= busyCnt + 1'b1;
  end

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= BUSY_W'(MAX_BUSY));

  a_r2_fall_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(wrDone));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrunErr |=> overrunErr);

  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    strobe.holdLoad |-> !holdFull);

  a_r5_ack_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    loadAck |-> (!ready && holdFull));

endmodule

// File: rtl/cfgser_datapath.sv
module cfgser_datapath
  import cfgser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  input  logic              holdFull,
  output logic              loadAck,
  output logic              serialOut
);

  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sampleReg;
  logic [DATA_W-1:0] dataDly [SYNC_STAGES];
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-2:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  // Bus sample while the raw write is active
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sampleReg <= '0;
    else if (strobe.captureEn) sampleReg <= dataIn;
  end

  // Delay line keeping the sample aligned with the strobe synchronizer
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_dly
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) dataDly[0] <= '0;
          else       dataDly[0] <= sampleReg;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) dataDly[gi] <= '0;
          else       dataDly[gi] <= dataDly[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                holdReg <= '0;
    else if (strobe.holdLoad) holdReg <= dataDly[SYNC_STAGES-1];
  end

  // Serializer on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      serialOut <= 1'b0;
      loadAck   <= 1'b0;
    end else if (bitCnt == '0 && holdFull) begin
      serialOut <= holdReg[0];
      shiftReg  <= holdReg[DATA_W-1:1];
      bitCnt    <= CNT_W'(DATA_W - 1);
      loadAck   <= 1'b1;
    end else begin
      loadAck <= 1'b0;
      if (bitCnt != '0) begin
        serialOut <= shiftReg[0];
        shiftReg  <= shiftReg >> 1;
        bitCnt    <= bitCnt - 1'b1;
      end
    end
  end

  a_r9_idle_hold: assert property (@(negedge clk) disable iff (!rstN)
    ($past(bitCnt) == '0 && bitCnt == '0 && !loadAck) |-> $stable(serialOut));

  a_r5_count_steps: assert property (@(negedge clk) disable iff (!rstN)
    (bitCnt != '0) |=> (loadAck || bitCnt == $past(bitCnt) - 1'b1));

endmodule

// File: rtl/cfg_byte_serializer.sv
module cfg_byte_serializer
  import cfgser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              rdN,
  input  logic [DATA_W-1:0] dataIn,
  output logic              ready,
  output logic              serialOut,
  output logic              d7Out,
  output logic              d7OutEn,
  output logic              overrunErr
);

  ctrlStrobe_t strobe;
  logic        holdFull;
  logic        loadAck;

  cfgser_ctrl #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .rdN(rdN), .loadAck(loadAck), .strobe(strobe),
    .holdFull(holdFull), .ready(ready), .overrunErr(overrunErr),
    .d7OutEn(d7OutEn)
  );

  cfgser_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobe(strobe),
    .holdFull(holdFull), .loadAck(loadAck), .serialOut(serialOut)
  );

  // Status mirrored onto bit 7 during reads
  assign d7Out = ready;

  a_r8_read_busy: assert property (@(posedge clk) disable iff (!rstN)
    (d7OutEn && !ready) |-> !d7Out);

endmodule

// File: tb/cfg_byte_serializer_bench.sv
module cfg_byte_serializer_bench;

  localparam time CLK_P = 8ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selLowN = 1'b1;
  logic       selHigh = 1'b0;
  logic       wrN = 1'b1;
  logic       rdN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic       ready, serialOut, d7Out, d7OutEn, overrunErr;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  cfg_byte_serializer u_cfg_byte_serializer (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .rdN(rdN), .dataIn(dataIn), .ready(ready),
    .serialOut(serialOut), .d7Out(d7Out), .d7OutEn(d7OutEn),
    .overrunErr(overrunErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Drive a selected write of the given length, then release with new data
  task automatic writeByte(input logic [7:0] value, input int cycles, input logic [7:0] after);
    selLowN = 1'b0; selHigh = 1'b1; wrN = 1'b0; dataIn = value;
    repeat (cycles) tick();
    wrN = 1'b1; dataIn = after;
  endtask

  task automatic waitReadyLow(output int cyc);
    cyc = 0;
    while (ready && cyc < 20) begin tick(); cyc++; end
  endtask

  task automatic testReset();
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(serialOut == 1'b0, "R1 serialOut", serialOut, 0);
    check(overrunErr == 1'b0, "R1 overrunErr", overrunErr, 0);
    check(d7OutEn == 1'b0, "R1 d7OutEn", d7OutEn, 0);
  endtask

  task automatic testDeselected();
    bit stayed = 1'b1;
    selLowN = 1'b0; selHigh = 1'b0; wrN = 1'b0; dataIn = 8'hFF;
    repeat (2) tick();
    wrN = 1'b1; selLowN = 1'b1; selHigh = 1'b1;
    tick();
    wrN = 1'b0;
    repeat (2) tick();
    wrN = 1'b1; selHigh = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (!ready || serialOut) stayed = 1'b0;
    end
    check(stayed, "R2 deselected write ignored", stayed, 1);
    check(overrunErr == 1'b0, "R2 no error", overrunErr, 0);
  endtask

  task automatic testSingle();
    logic [7:0] val = 8'hB4;
    logic [7:0] got = '0;
    int cyc, busy;
    tick();
    writeByte(8'h11, 1, 8'h11);     // earlier bus value that must be overwritten
    dataIn = val; wrN = 1'b0;
    tick();
    wrN = 1'b1; dataIn = 8'h00;     // R3: data changes as the strobe rises
    waitReadyLow(cyc);
    check(cyc >= 1 && cyc <= 4, "R4 ready falls", cyc, 3);
    busy = 0;
    fork
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); #1;
        got[i] = serialOut;
      end
      begin
        while (!ready && busy < 20) begin tick(); busy++; end
      end
    join
    check(got == val, "R3 R5 serial byte", got, val);
    check(busy >= 1 && busy <= 8, "R4 busy length", busy, 1);
    repeat (4) @(negedge clk);
    #1;
    check(serialOut == val[7], "R9 hold last bit", serialOut, val[7]);
    selLowN = 1'b0; selHigh = 1'b1; rdN = 1'b0;
    #1;
    check(d7OutEn && d7Out, "R8 read ready", {d7OutEn, d7Out}, 3);
    selLowN = 1'b1;
    #1;
    check(!d7OutEn, "R8 deselected read", d7OutEn, 0);
    rdN = 1'b1;
  endtask

  task automatic testStream();
    logic [7:0] a = 8'hA5, b = 8'h96, c = 8'h0F;
    logic [15:0] got = '0;
    int cyc;
    bit stable = 1'b1;
    tick();
    writeByte(a, 2, 8'h00);
    waitReadyLow(cyc);
    fork
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); #1;
        got[i] = serialOut;
      end
      begin
        while (!ready) tick();
        writeByte(b, 1, 8'h00);
        tick();
        writeByte(c, 1, 8'h00);
        tick();
        selLowN = 1'b0; selHigh = 1'b1; rdN = 1'b0;
        #1;
        check(d7OutEn && !d7Out, "R8 read busy", {d7OutEn, d7Out}, 2);
        rdN = 1'b1; selLowN = 1'b1; selHigh = 1'b0;
      end
    join
    check(got == {b, a}, "R6 back-to-back stream", got, {b, a});
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (serialOut != b[7]) stable = 1'b0;
    end
    check(stable, "R7 dropped byte absent", stable, 1);
    check(overrunErr == 1'b1, "R7 error set", overrunErr, 1);
    check(ready == 1'b1, "R7 ready after drop", ready, 1);
    repeat (5) tick();
    check(overrunErr == 1'b1, "R7 error sticky", overrunErr, 1);
  endtask

  initial begin : watchdog
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    testReset();
    rstN = 1'b1;
    repeat (2) tick();
    testReset();
    testDeselected();
    testSingle();
    testStream();
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    testReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule